// File: doc/BRIEF.md
# Wakeup Interrupt Polarity Normaliser

This block sits between a bank of raw wakeup interrupt lines and a downstream interrupt controller that only understands rising edges and active-high levels. Each input line has its own 3-bit trigger-type setting and an enable bit. The block synchronises every line, then turns it into a form the downstream controller accepts. Active-low levels and falling edges are inverted. Edge-triggered lines leave as one-cycle pulses. A dual-edge line pulses on every transition.

Software programs the block through a simple word-addressed register port: a write strobe, an address, write data and registered read data. Enable bits are packed 32 to a word. Each line has its own configuration word. Two read-only words report an identification version and the split of lines between direct interrupt lines and general-purpose lines. A change of a line's trigger type reloads that line's edge history, so reprogramming a line while its input is steady never produces a pulse of its own.

Top module: `wake_pol_norm`

## Requirements
- R1: The trigger type is bits [2:0] of a line's configuration word: 000 active-low level, 010 falling edge, 100 active-high level, 110 rising edge, 111 dual edge. The unused codes 001, 011 and 101 hold that line's output at 0.
- R2: An active-high level line outputs its input, and an active-low level line outputs its inverted input. An input change set up before clock edge A first shows at `irq_out` after edge A+2, through two synchroniser flops and one output register.
- R3: A rising-edge line gives a one-cycle pulse when its input goes from 0 to 1, and a falling-edge line gives a one-cycle pulse when its input goes from 1 to 0. No other input transition produces a pulse on these lines.
- R4: A dual-edge line gives a one-cycle pulse on every transition of its input, in either direction.
- R5: A line whose enable bit is 0 outputs 0. The enable bit of line p is bit p[4:0] of enable word p>>5, and enable word k is at address 0x008+k.
- R6: The configuration word of line p is at address 0x100+p. Writes to its bits [31:3] are ignored, and those bits read as 0.
- R7: A write that changes a line's trigger type produces no output pulse for that line when its input is held steady. A later real input edge is still detected.
- R8: The version word at address 0x000 holds major in [23:16], minor in [15:8] and step in [7:0], with [31:24] at 0. The parameter word at address 0x001 holds the number of general-purpose lines in [15:8] and the number of direct lines in [7:0].
- R9: After reset, all outputs are 0, all enable bits are 0 and every trigger type is 000. Read data is 0 until the first read after reset.
- R10: `reg_rdata` is registered. It shows the word addressed by `reg_addr` one clock edge after the address is presented. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_PINS | Raw interrupt lines, asynchronous to clk |
| irq_out | output | NUM_PINS | Normalised lines: active-high levels or rising pulses |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 9 | Word address for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |

## Verification
The hardest case to reach is a trigger-type rewrite that flips a line's polarity while its input is held still. Without the reload, this would look like an edge after normalisation. The bench parks a falling-edge line at a high input and a rising-edge line at a low input. It lets the history settle, rewrites each type to the opposite edge sense, and watches the line for several cycles. It then drives a genuine edge to confirm that detection still works. The main sweep gives the 64 lines the codes 0 to 7 in turn. It steps the whole input vector through patterns where every line toggles, none toggles or a mixture toggles, and checks the cycle before, the cycle of and the cycle after each change, with part of the bank disabled.

// File: rtl/wpn_pkg.sv
package wpn_pkg;

  localparam int ADDR_W    = 9;
  localparam int ADDR_VER  = 0;
  localparam int ADDR_PRM  = 1;
  localparam int BANK_BASE = 8;
  localparam int CFG_BASE  = 256;
  localparam int MAX_PINS  = 256;

  localparam logic [2:0] TRIG_LVL_LO = 3'b000;
  localparam logic [2:0] TRIG_FALL   = 3'b010;
  localparam logic [2:0] TRIG_LVL_HI = 3'b100;
  localparam logic [2:0] TRIG_RISE   = 3'b110;
  localparam logic [2:0] TRIG_BOTH   = 3'b111;

  function automatic logic trig_inverts(input logic [2:0] code);
    return (code == TRIG_LVL_LO) || (code == TRIG_FALL);
  endfunction

  function automatic logic trig_is_level(input logic [2:0] code);
    return (code == TRIG_LVL_LO) || (code == TRIG_LVL_HI);
  endfunction

  function automatic logic trig_is_single_edge(input logic [2:0] code);
    return (code == TRIG_FALL) || (code == TRIG_RISE);
  endfunction

endpackage

// File: rtl/wpn_sync.sv
module wpn_sync #(
  parameter int WIDTH  = 64,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d_async;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/wpn_regfile.sv
module wpn_regfile
  import wpn_pkg::*;
#(
  parameter int NUM_PINS   = 64,
  parameter int NUM_DIRECT = 24,
  parameter int VER_MAJOR  = 3,
  parameter int VER_MINOR  = 1,
  parameter int VER_STEP   = 0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [31:0]           wdata,
  output logic [31:0]           rdata,
  output logic [NUM_PINS-1:0]   en_vec,
  output logic [3*NUM_PINS-1:0] type_vec,
  output logic [NUM_PINS-1:0]   reload_vec
);

  localparam int NUM_BANKS = (NUM_PINS + 31) / 32;
  localparam int NUM_GPIO  = NUM_PINS - NUM_DIRECT;
  localparam logic [31:0] VER_WORD = {8'h00, 8'(VER_MAJOR), 8'(VER_MINOR), 8'(VER_STEP)};
  localparam logic [31:0] PRM_WORD = {16'h0000, 8'(NUM_GPIO), 8'(NUM_DIRECT)};

  logic [31:0] bank_q [NUM_BANKS];
  logic [2:0]  type_q [NUM_PINS];
  logic [31:0] rd_d;

  // Enable words: one register per bank
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        bank_q[b] <= '0;
      end else if (we && addr == ADDR_W'(BANK_BASE + b)) begin
        bank_q[b] <= wdata;
      end
    end
  end

  // Per-line type field and reload flag
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (rst) begin
        type_q[p]     <= TRIG_LVL_LO;
        reload_vec[p] <= 1'b0;
      end else begin
        reload_vec[p] <= 1'b0;
        if (we && addr == ADDR_W'(CFG_BASE + p)) begin
          type_q[p]     <= wdata[2:0];
          reload_vec[p] <= (wdata[2:0] != type_q[p]);
        end
      end
    end
    assign en_vec[p]          = bank_q[p / 32][p % 32];
    assign type_vec[3*p +: 3] = type_q[p];
  end

  always_comb begin
    rd_d = '0;
    if (addr == ADDR_W'(ADDR_VER)) rd_d = VER_WORD;
    if (addr == ADDR_W'(ADDR_PRM)) rd_d = PRM_WORD;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (addr == ADDR_W'(BANK_BASE + b)) rd_d = bank_q[b];
    end
    for (int p = 0; p < NUM_PINS; p++) begin
      if (addr == ADDR_W'(CFG_BASE + p)) rd_d = {29'd0, type_q[p]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_d;
  end

endmodule

// File: rtl/wpn_pin_norm.sv
module wpn_pin_norm
  import wpn_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sync_in,
  input  logic       enable,
  input  logic [2:0] trig,
  input  logic       reload,
  output logic       out
);

  logic norm;
  logic hist_q;
  logic edge_pos;
  logic edge_any;
  logic out_d;

  // Inverted types become active-high / rising after this XOR
  assign norm     = sync_in ^ trig_inverts(trig);
  assign edge_pos = norm & ~hist_q & ~reload;
  assign edge_any = (norm ^ hist_q) & ~reload;

  always_comb begin
    out_d = 1'b0;
    if (trig_is_level(trig))            out_d = norm;
    else if (trig_is_single_edge(trig)) out_d = edge_pos;
    else if (trig == TRIG_BOTH)         out_d = edge_any;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= 1'b0;
      out    <= 1'b0;
    end else begin
      hist_q <= norm;
      out    <= enable & out_d;
    end
  end

endmodule

// File: rtl/wake_pol_norm.sv
module wake_pol_norm
  import wpn_pkg::*;
#(
  parameter int NUM_PINS    = 64,
  parameter int NUM_DIRECT  = 24,
  parameter int SYNC_STAGES = 2,
  parameter int VER_MAJOR   = 3,
  parameter int VER_MINOR   = 1,
  parameter int VER_STEP    = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] irq_in,
  output logic [NUM_PINS-1:0] irq_out,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata
);

  logic [NUM_PINS-1:0]   sync_vec;
  logic [NUM_PINS-1:0]   en_vec;
  logic [3*NUM_PINS-1:0] type_vec;
  logic [NUM_PINS-1:0]   reload_vec;

  wpn_sync #(
    .WIDTH (NUM_PINS),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d_async(irq_in),
    .q_sync (sync_vec)
  );

  wpn_regfile #(
    .NUM_PINS  (NUM_PINS),
    .NUM_DIRECT(NUM_DIRECT),
    .VER_MAJOR (VER_MAJOR),
    .VER_MINOR (VER_MINOR),
    .VER_STEP  (VER_STEP)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .we        (reg_we),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .en_vec    (en_vec),
    .type_vec  (type_vec),
    .reload_vec(reload_vec)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    wpn_pin_norm u_pin (
      .clk    (clk),
      .rst    (rst),
      .sync_in(sync_vec[p]),
      .enable (en_vec[p]),
      .trig   (type_vec[3*p +: 3]),
      .reload (reload_vec[p]),
      .out    (irq_out[p])
    );
  end

endmodule

// File: rtl/wpn_checker.sv
module wpn_checker #(
  parameter int NUM_PINS = 64
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NUM_PINS-1:0]   irq_out,
  input logic [NUM_PINS-1:0]   en_vec,
  input logic [3*NUM_PINS-1:0] type_vec,
  input logic [NUM_PINS-1:0]   reload_vec
);

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (irq_out & ~$past(en_vec)) == '0) else $error("disabled line active"); // R5

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
    logic [2:0] t;
    logic       unused_code;
    logic       single_edge;
    logic       any_edge;
    assign t           = type_vec[3*i +: 3];
    assign unused_code = (t == 3'b001) || (t == 3'b011) || (t == 3'b101);
    assign single_edge = (t == 3'b010) || (t == 3'b110);
    assign any_edge    = single_edge || (t == 3'b111);

    AST_UNUSED_CODE_ZERO: assert property (@(posedge clk) disable iff (rst)
      $past(unused_code) |-> !irq_out[i]) else $error("unused code drove line"); // R1

    AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      (irq_out[i] && $past(single_edge) && $past(single_edge, 2)) |-> !$past(irq_out[i]))
      else $error("edge pulse longer than one cycle"); // R3

    AST_RELOAD_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
      (reload_vec[i] && any_edge) |=> !irq_out[i]) else $error("pulse on type change"); // R7
  end

endmodule

bind wake_pol_norm wpn_checker #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .irq_out   (irq_out),
  .en_vec    (en_vec),
  .type_vec  (type_vec),
  .reload_vec(reload_vec)
);

// File: tb/sim_wake_pol_norm.sv
module sim_wake_pol_norm;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] irq_in = '0;
  logic [NP-1:0] irq_out;
  logic          reg_we = 1'b0;
  logic [8:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [2:0]    code [NP];
  logic [NP-1:0] en_m = '0;
  logic [NP-1:0] cur = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_pol_norm u0 (
    .clk(clk), .rst(rst), .irq_in(irq_in), .irq_out(irq_out),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic check(input logic [NP-1:0] act, input logic [NP-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [NP-1:0] expv(input logic [NP-1:0] nv, input logic [NP-1:0] ov);
    logic [NP-1:0] r = '0;
    for (int p = 0; p < NP; p++) begin
      logic b;
      case (code[p])
        3'b100:  b = nv[p];
        3'b000:  b = ~nv[p];
        3'b110:  b = nv[p] & ~ov[p];
        3'b010:  b = ~nv[p] & ov[p];
        3'b111:  b = nv[p] ^ ov[p];
        default: b = 1'b0;
      endcase
      r[p] = b & en_m[p];
    end
    return r;
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 9'(a); reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 9'(a);
    @(posedge clk);
    @(negedge clk);
    d = reg_rdata;
    reg_addr = '0;
  endtask

  task automatic step(input logic [NP-1:0] nv, input string tag);
    logic [NP-1:0] ov;
    ov = cur;
    @(negedge clk);
    irq_in = nv; cur = nv;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check(irq_out, expv(ov, ov), {tag, " R2 before change"});
    @(posedge clk); @(negedge clk);
    check(irq_out, expv(nv, ov), {tag, " R2 R3 R4 change cycle"});
    @(posedge clk); @(negedge clk);
    check(irq_out, expv(nv, nv), {tag, " R3 R4 after change"});
    repeat (2) @(posedge clk);
  endtask

  task automatic watch_quiet(input int bitn, input int n, input string tag);
    logic seen = 1'b0;
    repeat (n) begin
      @(negedge clk);
      if (irq_out[bitn]) seen = 1'b1;
    end
    check({63'd0, seen}, '0, tag);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired act=hung exp=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int p = 0; p < NP; p++) code[p] = 3'b000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(irq_out, '0, "R9 reset outputs");
    check({32'd0, reg_rdata}, '0, "R9 reset rdata");
    rst = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(irq_out, '0, "R9 enables clear after reset");

    rd(0, d); check({32'd0, d}, 64'h0003_0100, "R8 R10 version word");
    rd(1, d); check({32'd0, d}, 64'h0000_2818, "R8 parameter word");
    rd(3, d); check({32'd0, d}, '0, "R10 unmapped address");
    rd(256 + 7, d); check({32'd0, d}, '0, "R9 reset type code");

    for (int p = 0; p < NP; p++) begin
      code[p] = 3'(p % 8);
      wr(256 + p, 32'(p % 8));
    end
    wr(8, 32'hFFFF_FFFF);
    wr(9, 32'hFFFF_0000);
    en_m = {32'hFFFF_0000, 32'hFFFF_FFFF};
    rd(256 + 5, d); check({32'd0, d}, 64'd5, "R6 config readback");
    rd(9, d); check({32'd0, d}, 64'hFFFF_0000, "R5 bank readback");
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(irq_out, expv(cur, cur), "R1 R2 steady after setup");

    step('1, "sweep ones");
    step('0, "sweep zeros");
    step(64'hA5A5_A5A5_A5A5_A5A5, "sweep a5");
    step(64'h5A5A_5A5A_5A5A_5A5A, "sweep 5a");
    step(64'h0123_4567_89AB_CDEF, "sweep mix");
    step(64'h0123_4567_89AB_CDEF, "sweep hold");
    step(64'hFEDC_BA98_7654_3210, "sweep mix2");
    step('0, "sweep back");

    wr(9, 32'hFFFF_FFFF);
    en_m = '1;
    step('1, "R5 all enabled ones");
    step(64'hF0F0_0F0F_F0F0_0F0F, "all enabled mix");
    step('0, "all enabled zeros");

    // R7: rising line 6 with input low, switched to falling sense
    wr(256 + 6, 32'h2); code[6] = 3'b010;
    watch_quiet(6, 6, "R7 rise to fall with input low");
    wr(256 + 6, 32'h6); code[6] = 3'b110;
    watch_quiet(6, 6, "R7 fall to rise with input low");
    // R7: falling line 2 with input high, switched to rising sense
    step(64'h4, "R3 line2 high");
    wr(256 + 2, 32'h6); code[2] = 3'b110;
    watch_quiet(2, 6, "R7 fall to rise with input high");
    step(64'h0, "R7 line2 drop");
    step(64'h4, "R7 line2 real rising edge");

    // R5 bank/bit mapping: only line 37 enabled
    wr(8, 32'h0);
    wr(9, 32'h20);
    wr(256 + 37, 32'h4); code[37] = 3'b100;
    en_m = '0; en_m[37] = 1'b1;
    step('1, "R5 mapping");
    check(irq_out, 64'h0000_0020_0000_0000, "R5 only line 37");

    // R6 upper bits ignored
    wr(256 + 12, 32'hFFFF_FFFC);
    rd(256 + 12, d); check({32'd0, d}, 64'd4, "R6 upper bits ignored");
    wr(256 + 13, 32'hFFFF_FFF9);
    rd(256 + 13, d); check({32'd0, d}, 64'd1, "R1 R6 unused code stored");

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule